// File: doc/BRIEF.md
# PHY Control-Register Port Responder

This block is the target end of a narrow strobe-and-acknowledge port used to reach configuration words inside a physical-layer macro. A master drives one of four strobes together with a 16-bit input word. The responder acts on that strobe, raises a single acknowledge, and keeps it high until the master lowers every strobe. The master then waits for the acknowledge to drop before it starts the next step. One access therefore costs a four-phase handshake.

A write takes three separate handshakes. The first latches an address. The second latches a pending data word. A third, distinct strobe then commits the pending word to the latched address. A read takes two handshakes: one latches the address, and the read strobe then presents the stored word on the output.

Storage is sparse. Only a parameterised list of addresses holds words, and every other address reads as zero. A response-latency parameter lets a master be tested against a slow target. Raising more than one strobe at once draws no acknowledge, so a master's timeout path can be exercised. The block models port behaviour only and has no analog function.

Top module: `phy_cr_responder`

## Requirements
- R1: After a synchronous active-low reset, ack_o is 0, data_o is 0, and every implemented word reads back as 0x0000.
- R2: When exactly one strobe is high while the port is idle, ack_o rises exactly LATENCY clock edges later, counting the edge that samples the strobe as the first. The default LATENCY is 3, and the legal range is 1 to 4. While any strobe stays high, ack_o stays high. An idle port never drives ack_o high.
- R3: At the first clock edge where all four strobes are low while ack_o is high, ack_o falls. After that the port is idle again.
- R4: A handshake on cap_addr_i latches data_i as the current address, and later reads and writes use that address.
- R5: A handshake on cap_data_i latches data_i as pending data and leaves the stored words unchanged. A later handshake on wr_i copies the pending data into the word at the current address.
- R6: A handshake on rd_i loads data_o with the word at the current address. data_o holds that value at least until ack_o has fallen, and it changes only on a later read.
- R7: Any address outside the implemented list reads as 0x0000, and a write to such an address changes no implemented word.
- R8: If two or more strobes are high together while the port is idle, ack_o stays 0 and the current address, the pending data and all stored words are left unchanged.
- R9: The implemented addresses 0x0030, 0x1002, 0x1006, 0x1010 and 0x102D each hold an independent 16-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_addr_i | input | 1 | Strobe: latch data_i as the address |
| cap_data_i | input | 1 | Strobe: latch data_i as pending write data |
| rd_i | input | 1 | Strobe: read the word at the current address |
| wr_i | input | 1 | Strobe: commit pending data to the current address |
| data_i | input | 16 | Address or data word from the master |
| ack_o | output | 1 | Four-phase acknowledge |
| data_o | output | 16 | Result of the last read |

## Verification
The assertions assume that the master lowers its strobe only after it has seen ack_o. They also assume that it raises a new strobe only once ack_o is low again, so that a strobe never appears or changes while a response is still counting. The bench respects this. Every access goes through one task, which raises a single strobe on a falling edge, waits for ack_o, and holds the strobe for a random 0 to 3 extra cycles. It then lowers all strobes and waits for ack_o to fall before it continues. Strobe conflicts are applied only while the port is idle, which is the one case where the stimulus breaks the single-strobe rule on purpose.

// File: rtl/phy_cr_pkg.sv
// Package: shared types and defaults for the control-register port responder.
// Assumes ADDR_W of 16 for the default address map.
package phy_cr_pkg;

    // Decoded request presented by the strobe lines
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ADDR     = 3'd1,
        OP_DATA     = 3'd2,
        OP_READ     = 3'd3,
        OP_WRITE    = 3'd4,
        OP_CONFLICT = 3'd5
    } cr_op_e;

    // Handshake phases
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    localparam int unsigned CR_MAX_LATENCY = 4;
    localparam int unsigned CR_DEF_REGS    = 5;

    // Default map, entry 0 in the low bits
    localparam logic [CR_DEF_REGS*16-1:0] CR_DEF_MAP = {
        16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030
    };

endpackage

// File: rtl/phy_cr_strobe_dec.sv
// Module: turns the four strobe lines into one request code.
// Assumes nothing about strobe timing. More than one high line yields OP_CONFLICT.
module phy_cr_strobe_dec
    import phy_cr_pkg::*;
(
    input  logic   cap_addr_i,
    input  logic   cap_data_i,
    input  logic   rd_i,
    input  logic   wr_i,
    output cr_op_e op_o,
    output logic   any_o
);

    logic [3:0] lines;
    logic [2:0] high_cnt;

    // Count the active lines
    always_comb begin
        lines    = {cap_addr_i, cap_data_i, rd_i, wr_i};
        high_cnt = 3'(lines[0]) + 3'(lines[1]) + 3'(lines[2]) + 3'(lines[3]);
        any_o    = (high_cnt != 3'd0);
    end

    // Map a single active line to its request
    always_comb begin
        if (high_cnt == 3'd0) begin
            op_o = OP_NONE;
        end else if (high_cnt > 3'd1) begin
            op_o = OP_CONFLICT;
        end else if (cap_addr_i) begin
            op_o = OP_ADDR;
        end else if (cap_data_i) begin
            op_o = OP_DATA;
        end else if (rd_i) begin
            op_o = OP_READ;
        end else begin
            op_o = OP_WRITE;
        end
    end

endmodule

// File: rtl/phy_cr_handshake.sv
// Module: four-phase acknowledge sequencer with a programmable response delay.
// Accepts a request only while idle, pulses fire_o on the accepting edge,
// raises ack after LATENCY edges, and releases it once all strobes are low.
// Assumes 1 <= LATENCY <= CR_MAX_LATENCY.
module phy_cr_handshake
    import phy_cr_pkg::*;
#(
    parameter int unsigned LATENCY = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  cr_op_e op_i,
    input  logic   any_i,
    output logic   fire_o,
    output logic   ack_o,
    output logic   busy_o
);

    localparam int unsigned CNT_W = $clog2(CR_MAX_LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    hs_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             single;

    // A request is accepted only when exactly one line is high
    always_comb begin
        single = (op_i != OP_NONE) && (op_i != OP_CONFLICT);
        fire_o = (state_q == HS_IDLE) && single;
        ack_o  = (state_q == HS_ACK);
        busy_o = (state_q != HS_IDLE);
    end

    // Phase sequencing and delay count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (fire_o) begin
                        if (LATENCY <= 1) begin
                            state_q <= HS_ACK;
                        end else begin
                            state_q <= HS_WAIT;
                            cnt_q   <= CNT_LOAD;
                        end
                    end
                end
                HS_WAIT: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        state_q <= HS_ACK;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                HS_ACK: begin
                    if (!any_i) begin
                        state_q <= HS_IDLE;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_cr_regfile.sv
// Module: sparse word store. Holds one word for each address in IMPL_MAP
// (entry g in bits g*ADDR_W upward). Other addresses read zero and ignore writes.
// Assumes the addresses in the map are distinct.
module phy_cr_regfile #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_REGS = 5,
    parameter logic [NUM_REGS*ADDR_W-1:0] IMPL_MAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [NUM_REGS-1:0] match;
    logic [DATA_W-1:0]   words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        // Compare the address with this slot
        assign match[g] = (addr_i == IMPL_MAP[g*ADDR_W +: ADDR_W]);

        // Hold the word for this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr_en_i && match[g]) begin
                words[g] <= wr_data_i;
            end
        end
    end

    // Combine the matching slot. No match yields zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (match[i]) begin
                rd_data_o = rd_data_o | words[i];
            end
        end
    end

endmodule

// File: rtl/phy_cr_responder.sv
// Module: target side of the strobe/acknowledge control-register port.
// Latches the address and pending data, commits writes, presents reads, and
// runs the four-phase acknowledge. Assumes the master keeps to one strobe per
// handshake and waits for ack to fall before the next one.
module phy_cr_responder
    import phy_cr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LATENCY  = 3,
    parameter int unsigned NUM_REGS = CR_DEF_REGS,
    parameter logic [NUM_REGS*ADDR_W-1:0] IMPL_MAP = CR_DEF_MAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_addr_i,
    input  logic              cap_data_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] data_o
);

    cr_op_e            op;
    logic              any_strobe;
    logic              fire;
    logic              hs_busy;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] data_q;
    logic              commit;

    phy_cr_strobe_dec u_dec (
        .cap_addr_i (cap_addr_i),
        .cap_data_i (cap_data_i),
        .rd_i       (rd_i),
        .wr_i       (wr_i),
        .op_o       (op),
        .any_o      (any_strobe)
    );

    phy_cr_handshake #(
        .LATENCY (LATENCY)
    ) u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .any_i  (any_strobe),
        .fire_o (fire),
        .ack_o  (ack_o),
        .busy_o (hs_busy)
    );

    // Write commit happens on the accepting edge of a write request
    assign commit = fire && (op == OP_WRITE);

    phy_cr_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IMPL_MAP (IMPL_MAP)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (commit),
        .addr_i    (addr_q),
        .wr_data_i (pend_q),
        .rd_data_o (rd_word)
    );

    // Latch the address, the pending data and the read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            data_q <= '0;
        end else if (fire) begin
            unique case (op)
                OP_ADDR: addr_q <= data_i[ADDR_W-1:0];
                OP_DATA: pend_q <= data_i;
                OP_READ: data_q <= rd_word;
                default: ;
            endcase
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/phy_cr_responder_chk.sv
// Checker: port-level properties of the responder, bound to every instance.
// Assumes the master obeys the single-strobe, four-phase discipline.
module phy_cr_responder_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_addr_i,
    input logic              cap_data_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic              ack_o,
    input logic [DATA_W-1:0] data_o,
    input logic              busy
);

    logic [3:0] strb;
    assign strb = {cap_addr_i, cap_data_i, rd_i, wr_i};

    // R2
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (strb != 4'b0)) |=> ack_o);

    // R2
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ack_o);

    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (strb == 4'b0)) |=> !ack_o);

    // R6
    rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(ack_o)) |-> $stable(data_o));

    // R8
    conflict_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ($countones(strb) > 1)) |=> (!ack_o && !busy));

endmodule

bind phy_cr_responder phy_cr_responder_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_addr_i (cap_addr_i),
    .cap_data_i (cap_data_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .ack_o      (ack_o),
    .data_o     (data_o),
    .busy       (hs_busy)
);

// File: tb/test_phy_cr_responder.sv
// Bench: mixes directed corner cases with seeded random accesses. A bench-side
// model of the sparse store supplies every expected value.
module test_phy_cr_responder;

    localparam int LAT = 3;
    localparam int NREG = 5;
    localparam logic [15:0] IMPL [NREG] = '{16'h0030, 16'h1002, 16'h1006, 16'h1010, 16'h102D};

    // Strobe vector order used by the bench: {cap_addr, cap_data, rd, wr}
    localparam logic [3:0] S_ADDR = 4'b1000;
    localparam logic [3:0] S_DATA = 4'b0100;
    localparam logic [3:0] S_RD   = 4'b0010;
    localparam logic [3:0] S_WR   = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strb = 4'b0;
    logic [15:0] din = 16'h0;
    logic        ack;
    logic [15:0] dout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] model [NREG];
    logic [15:0] last_rd;

    always #4 clk = ~clk;

    phy_cr_responder i_phy_cr_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_addr_i (strb[3]),
        .cap_data_i (strb[2]),
        .rd_i       (strb[1]),
        .wr_i       (strb[0]),
        .data_i     (din),
        .ack_o      (ack),
        .data_o     (dout)
    );

    function automatic int ref_idx(input logic [15:0] a);
        for (int i = 0; i < NREG; i++) if (IMPL[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [15:0] ref_read(input logic [15:0] a);
        int k = ref_idx(a);
        return (k < 0) ? 16'h0 : model[k];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One four-phase handshake with latency, hold and release checks
    task automatic hs(input logic [3:0] s, input logic [15:0] d, input int hold);
        int lat;
        logic [15:0] snap;
        @(negedge clk);
        strb = s;
        din = d;
        lat = 0;
        while (!ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == LAT, "R2 ack latency", lat, LAT);
        snap = dout;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(ack == 1'b1, "R2 ack held", ack, 1);
            check(dout == snap, "R6 data_o stable", dout, snap);
        end
        strb = 4'b0;
        @(negedge clk);
        check(ack == 1'b0, "R3 ack release", ack, 0);
        last_rd = dout;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int hold);
        int k;
        hs(S_ADDR, a, hold);
        hs(S_DATA, d, hold);
        hs(S_WR, 16'hDEAD, hold);
        k = ref_idx(a);
        if (k >= 0) model[k] = d;
    endtask

    task automatic do_read(input logic [15:0] a, input int hold, input string req);
        hs(S_ADDR, a, hold);
        hs(S_RD, 16'h0, hold);
        check(last_rd == ref_read(a), req, last_rd, ref_read(a));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, d;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        for (int i = 0; i < NREG; i++) model[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ack == 1'b0, "R1 ack after reset", ack, 0);
        check(dout == 16'h0, "R1 data_o after reset", dout, 0);
        for (int i = 0; i < NREG; i++) do_read(IMPL[i], 0, "R1 reset word");

        // R9 independent words, R4 address latch
        for (int i = 0; i < NREG; i++) do_write(IMPL[i], 16'hA500 + 16'(i * 17), i % 3);
        for (int i = NREG - 1; i >= 0; i--) do_read(IMPL[i], 1, "R9 word readback");

        // R5 capture-data alone leaves the word unchanged, then write commits it
        hs(S_ADDR, 16'h1010, 0);
        hs(S_DATA, 16'h7E57, 2);
        hs(S_RD, 16'h0, 0);
        check(last_rd == model[3], "R5 no commit before write", last_rd, model[3]);
        hs(S_WR, 16'h0, 0);
        model[3] = 16'h7E57;
        do_read(16'h1010, 0, "R5 commit by write");

        // R7 unimplemented address
        do_write(16'h1011, 16'hFFFF, 0);
        do_read(16'h1011, 0, "R7 unimplemented reads zero");
        for (int i = 0; i < NREG; i++) do_read(IMPL[i], 0, "R7 write discarded");

        // R8 conflicting strobes while idle
        hs(S_ADDR, 16'h0030, 0);
        hs(S_DATA, 16'h1234, 0);
        @(negedge clk);
        strb = S_ADDR | S_WR;
        din = 16'h1002;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(ack == 1'b0, "R8 no ack on conflict", ack, 0);
        end
        strb = S_DATA | S_RD;
        din = 16'h4321;
        repeat (4) begin
            @(negedge clk);
            check(ack == 1'b0, "R8 no ack on conflict", ack, 0);
        end
        strb = 4'b0;
        @(negedge clk);
        hs(S_RD, 16'h0, 0);
        check(last_rd == model[0], "R8 address and word unchanged", last_rd, model[0]);
        hs(S_WR, 16'h0, 0);
        model[0] = 16'h1234;
        do_read(16'h0030, 0, "R8 pending data unchanged");

        // Random traffic
        for (int n = 0; n < 80; n++) begin
            if ($urandom_range(0, 3) != 0) a = IMPL[$urandom_range(0, NREG - 1)];
            else begin
                a = 16'($urandom);
                while (ref_idx(a) >= 0) a = a + 16'd1;
            end
            d = 16'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, d, $urandom_range(0, 3));
            else do_read(a, $urandom_range(0, 3), "R4 random read");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule